// File: doc/BRIEF.md
# Single-Bank DRAM Timing Model

This block is a cycle-accurate behavioural model of one DRAM bank that has a single row buffer. A memory scheduler hands it one word command at a time, either a read or a write, over a valid/ready handshake. The bank then spends cycles according to the state of its row buffer. If the target row is already open, it performs only the column access. If no row is open, it activates the row and then does the column access. If a different row is open, it first writes that row back, then activates the new row, then does the column access. The row phases last `ROW_DELAY` cycles each and the column phase lasts `COL_DELAY` cycles. When the command finishes, the block raises a one-cycle completion pulse that carries the request tag and the read data.

The data space is split evenly among `NUM_CORES` cores. The model checks every command against its core's slice and against word alignment. A command that fails either check is refused: it touches neither memory nor the row buffer, and it completes with an error flag. The open row index and its valid bit are outputs, so the scheduler can tell row hits from misses. A mode input selects the blocking behaviour. When blocking is on, the model stalls the core whose command is in flight. When it is off, the stall outputs stay low and the core keeps issuing work.

Top module: `dram_bank_model`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in flight; it drops in the cycle after a command is accepted and is high again in the cycle in which `done_valid` is high.
- R2: A command to the open row (a row hit) completes `COL_DELAY` cycles after the accepting clock edge.
- R3: With no row open (after reset), a valid command completes `ROW_DELAY + COL_DELAY` cycles after acceptance and performs no writeback.
- R4: A command to a row other than the open row completes `2*ROW_DELAY + COL_DELAY` cycles after acceptance, going through writeback, activation and column access.
- R5: `done_valid` lasts exactly one cycle and carries the tag of the command. For reads, `done_rdata` holds the last word written to that address. For writes and refused commands, `done_rdata` is zero.
- R6: A command whose byte address has `cmd_addr[1:0]` not equal to 0 is refused. It completes with `done_error`=1 one cycle after acceptance, leaves memory and the row state unchanged, and returns zero data.
- R7: Core c owns the byte addresses whose top `$clog2(NUM_CORES)` bits equal c. A command outside its own slice is refused with `done_error`=1 one cycle after acceptance, and its write is not performed.
- R8: After reset `open_row_valid` is 0. After a successful command, `open_row` equals the target row, which is `cmd_addr[ADDR_W-1:COL_W+2]`, and `open_row_valid` is 1.
- R9: With `blocking_mode`=1, bit c of `core_stall` is high from the cycle after core c's command is accepted until its completion cycle, in which it is low. With `blocking_mode`=0, `core_stall` stays all zero.
- R10: During and after reset, `done_valid` is low, `cmd_ready` is high and `core_stall` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blocking_mode | input | 1 | 1: stall the issuing core until completion |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Bank idle, command can be taken |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_core | input | CORE_W | Issuing core |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_tag | input | TAG_W | Request tag |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of completed command |
| done_rdata | output | DATA_W | Read data, zero for writes and errors |
| done_error | output | 1 | Command refused (alignment or slice) |
| core_stall | output | NUM_CORES | Per-core stall in blocking mode |
| open_row | output | ROW_W | Row held in the row buffer |
| open_row_valid | output | 1 | Row buffer holds a row |

## Verification
The main function is exercised with three kinds of command stream. The first is a repeated access to one row, which isolates the column-only path. The second is an alternating pair of rows, which forces writeback and activation each time and so separates the miss latency from the hit and empty-buffer latencies. The third is a first access after reset, which must skip the writeback. Misaligned and foreign-slice commands are placed between valid ones. A following read of the same word then shows that a refused write changed nothing and that the open row survived the refusal. Each stream is run once with blocking on and once with it off, which separates the per-core stall behaviour from the latency behaviour.

// File: rtl/dbm_pkg.sv
// Shared types for the single-bank DRAM timing model.
// Assumes: nothing beyond IEEE 1800-2017.
package dbm_pkg;
    // Activity phase of the bank.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WB   = 3'd1,
        PH_ACT  = 3'd2,
        PH_COL  = 3'd3,
        PH_ERR  = 3'd4
    } phase_e;
endpackage

// File: rtl/dbm_addr_check.sv
// Splits a byte address into row and word index and checks it against
// alignment and the issuing core's slice.
// Assumes: NUM_CORES is a power of two; slices are equal, contiguous and in core order.
module dbm_addr_check #(
    parameter int ADDR_W    = 10,
    parameter int NUM_CORES = 4,
    parameter int COL_W     = 4
) (
    input  logic [$clog2(NUM_CORES)-1:0]  core,
    input  logic [ADDR_W-1:0]             addr,
    output logic                          misaligned,
    output logic                          foreign,
    output logic [ADDR_W-COL_W-3:0]       row,
    output logic [ADDR_W-3:0]             word_idx
);
    localparam int CORE_W = $clog2(NUM_CORES);

    // Decode fields and flag bad accesses.
    always_comb begin
        misaligned = (addr[1:0] != 2'b00);
        foreign    = (addr[ADDR_W-1 -: CORE_W] != core);
        word_idx   = addr[ADDR_W-1:2];
        row        = addr[ADDR_W-1:COL_W+2];
    end
endmodule

// File: rtl/dbm_phase_ctrl.sv
// Sequences writeback, activate and column phases, each counted down from
// its configured latency. It flags the last cycle of each phase.
// Assumes: ROW_DELAY and COL_DELAY are at least 1.
module dbm_phase_ctrl
    import dbm_pkg::*;
#(
    parameter int ROW_DELAY = 3,
    parameter int COL_DELAY = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_err,
    input  logic   start_hit,
    input  logic   start_empty,
    output phase_e phase,
    output logic   last
);
    localparam int MAX_D = (ROW_DELAY > COL_DELAY) ? ROW_DELAY : COL_DELAY;
    localparam int CNT_W = $clog2(MAX_D + 1);
    localparam logic [CNT_W-1:0] ROW_LD = CNT_W'(ROW_DELAY - 1);
    localparam logic [CNT_W-1:0] COL_LD = CNT_W'(COL_DELAY - 1);

    logic [CNT_W-1:0] cnt;

    // Phase transitions and per-phase countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    if (start_err) begin
                        phase <= PH_ERR;
                        cnt   <= '0;
                    end else if (start_hit) begin
                        phase <= PH_COL;
                        cnt   <= COL_LD;
                    end else if (start_empty) begin
                        phase <= PH_ACT;
                        cnt   <= ROW_LD;
                    end else begin
                        phase <= PH_WB;
                        cnt   <= ROW_LD;
                    end
                end
                PH_WB: if (cnt == '0) begin
                    phase <= PH_ACT;
                    cnt   <= ROW_LD;
                end else cnt <= cnt - 1'b1;
                PH_ACT: if (cnt == '0) begin
                    phase <= PH_COL;
                    cnt   <= COL_LD;
                end else cnt <= cnt - 1'b1;
                PH_COL: if (cnt == '0) phase <= PH_IDLE;
                        else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Final cycle of the current phase.
    assign last = (phase != PH_IDLE) && (cnt == '0);
endmodule

// File: rtl/dbm_word_store.sv
// Word array of the bank with one access port; read data is registered
// and is zero after a write or a clear.
// Assumes: at most one access per cycle; array contents are not reset.
module dbm_word_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              access,
    input  logic              write,
    input  logic              clr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << IDX_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Array write.
    always_ff @(posedge clk) begin
        if (access && write) mem[idx] <= wdata;
    end

    // Registered read result.
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata <= '0;
        else if (clr)         rdata <= '0;
        else if (access)      rdata <= write ? '0 : mem[idx];
    end
endmodule

// File: rtl/dram_bank_model.sv
// Single-bank DRAM timing model: takes one command when idle, runs the
// writeback/activate/column phases that the row-buffer state requires,
// then pulses done with tag and data. Refuses misaligned or foreign-slice
// commands. Tracks the open row and drives per-core stalls in blocking mode.
// Assumes: NUM_CORES is a power of two; delays are at least 1.
module dram_bank_model
    import dbm_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 4,
    parameter int ROW_DELAY = 3,
    parameter int COL_DELAY = 2,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int ROW_W    = ADDR_W - COL_W - 2,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blocking_mode,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_write,
    input  logic [CORE_W-1:0]     cmd_core,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic [TAG_W-1:0]      cmd_tag,
    output logic                  done_valid,
    output logic [TAG_W-1:0]      done_tag,
    output logic [DATA_W-1:0]     done_rdata,
    output logic                  done_error,
    output logic [NUM_CORES-1:0]  core_stall,
    output logic [ROW_W-1:0]      open_row,
    output logic                  open_row_valid
);
    logic              accept, bad, misaligned, foreign, hit;
    logic [ROW_W-1:0]  in_row, row_q;
    logic [IDX_W-1:0]  in_idx, idx_q;
    logic              write_q;
    logic [CORE_W-1:0] core_q;
    logic [DATA_W-1:0] wdata_q, st_rdata;
    logic [TAG_W-1:0]  tag_q;
    phase_e            phase;
    logic              last, col_end;

    dbm_addr_check #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .COL_W(COL_W)) u_chk_addr (
        .core(cmd_core), .addr(cmd_addr), .misaligned(misaligned),
        .foreign(foreign), .row(in_row), .word_idx(in_idx)
    );

    // Handshake and request classification.
    always_comb begin
        cmd_ready = (phase == PH_IDLE);
        accept    = cmd_valid && cmd_ready;
        bad       = misaligned || foreign;
        hit       = open_row_valid && (open_row == in_row);
    end

    dbm_phase_ctrl #(.ROW_DELAY(ROW_DELAY), .COL_DELAY(COL_DELAY)) u_phase (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_err(bad),
        .start_hit(hit), .start_empty(!open_row_valid),
        .phase(phase), .last(last)
    );

    assign col_end = (phase == PH_COL) && last;

    // Latch the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            core_q  <= '0;
            row_q   <= '0;
            idx_q   <= '0;
            wdata_q <= '0;
            tag_q   <= '0;
        end else if (accept) begin
            write_q <= cmd_write;
            core_q  <= cmd_core;
            row_q   <= in_row;
            idx_q   <= in_idx;
            wdata_q <= cmd_wdata;
            tag_q   <= cmd_tag;
        end
    end

    // Row-buffer state: closed by writeback, opened by activation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row       <= '0;
            open_row_valid <= 1'b0;
        end else if (phase == PH_WB && last) begin
            open_row_valid <= 1'b0;
        end else if (phase == PH_ACT && last) begin
            open_row       <= row_q;
            open_row_valid <= 1'b1;
        end
    end

    dbm_word_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .access(col_end), .write(write_q),
        .clr(phase == PH_ERR), .idx(idx_q), .wdata(wdata_q), .rdata(st_rdata)
    );

    // Completion pulse with tag and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_tag   <= '0;
            done_error <= 1'b0;
        end else begin
            done_valid <= col_end || (phase == PH_ERR);
            done_tag   <= tag_q;
            done_error <= (phase == PH_ERR);
        end
    end

    assign done_rdata = st_rdata;

    // Per-core stall while that core's command is in flight (blocking mode).
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_stall
        assign core_stall[g] = blocking_mode && (phase != PH_IDLE) && (core_q == CORE_W'(g));
    end
endmodule

// File: rtl/dbm_checker.sv
// Temporal checks on the DRAM bank model ports, bound to every instance.
// Assumes: synchronous active-low reset.
module dbm_checker #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic [ADDR_W-1:0]    cmd_addr,
    input logic                 done_valid,
    input logic                 done_error,
    input logic [DATA_W-1:0]    done_rdata,
    input logic [NUM_CORES-1:0] core_stall,
    input logic [ROW_W-1:0]     open_row,
    input logic                 open_row_valid
);
    // R1: an accepted command makes the bank busy in the next cycle.
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R5: completion is a single-cycle pulse.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R6: a misaligned command completes with error one cycle after acceptance.
    assert_misaligned_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_addr[1:0] != 2'b00) |=> ##1 (done_valid && done_error));

    // R5: refused commands return zero data.
    assert_err_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_error) |-> (done_rdata == '0));

    // R8: the row buffer does not change in the cycle after an idle cycle.
    assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |=> ($stable(open_row) && $stable(open_row_valid)));

    // R9: at most one core is stalled at a time.
    assert_one_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(core_stall));
endmodule

bind dram_bank_model dbm_checker #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_W(ROW_W)
) u_dbm_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .done_valid(done_valid), .done_error(done_error),
    .done_rdata(done_rdata), .core_stall(core_stall), .open_row(open_row),
    .open_row_valid(open_row_valid)
);

// File: tb/dram_bank_model_test.sv
// Scoreboard bench: the driver predicts each completion (cycle, tag, data,
// error, row state) into a queue and the monitor compares completions in order.
module dram_bank_model_test;
    localparam int NC = 4, AW = 10, CW = 4, DW = 32, TW = 4;
    localparam int RD = 3, CD = 2;
    localparam int RW = AW - CW - 2;

    logic          clk = 1'b0, rst_n = 1'b0, blocking_mode = 1'b1;
    logic          cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
    logic [1:0]    cmd_core = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [TW-1:0] cmd_tag = '0;
    logic          done_valid, done_error, open_row_valid;
    logic [TW-1:0] done_tag;
    logic [DW-1:0] done_rdata;
    logic [NC-1:0] core_stall;
    logic [RW-1:0] open_row;

    int unsigned cyc = 0;
    int n_checks = 0, n_fails = 0;

    typedef struct {
        logic [TW-1:0] tag;
        logic [DW-1:0] rdata;
        logic          err;
        int unsigned   when;
        logic [RW-1:0] row;
        logic          rowv;
        string         req;
    } exp_t;
    exp_t sb[$];

    logic [DW-1:0] ref_mem [256];
    logic [RW-1:0] m_row = '0;
    logic          m_rowv = 1'b0;

    dram_bank_model #(.NUM_CORES(NC), .ADDR_W(AW), .COL_W(CW), .DATA_W(DW),
                      .TAG_W(TW), .ROW_DELAY(RD), .COL_DELAY(CD)) uut (
        .clk(clk), .rst_n(rst_n), .blocking_mode(blocking_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_core(cmd_core), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_tag(cmd_tag), .done_valid(done_valid), .done_tag(done_tag),
        .done_rdata(done_rdata), .done_error(done_error), .core_stall(core_stall),
        .open_row(open_row), .open_row_valid(open_row_valid)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: offer one command, predict its completion, check handshake/stall.
    task automatic issue(bit wr, logic [1:0] core, logic [AW-1:0] addr,
                         logic [DW-1:0] data, logic [TW-1:0] tag, string req);
        exp_t e;
        int lat;
        bit err;
        logic [RW-1:0] row;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = wr; cmd_core = core;
        cmd_addr = addr; cmd_wdata = data; cmd_tag = tag;
        err = (addr[1:0] != 2'b00) || (addr[AW-1:AW-2] != core);
        row = addr[AW-1:CW+2];
        e.tag = tag; e.err = err; e.req = req; e.rdata = '0;
        if (err) begin
            lat = 1;
        end else begin
            if (m_rowv && m_row == row) lat = CD;
            else if (!m_rowv)           lat = RD + CD;
            else                        lat = 2 * RD + CD;
            m_row = row; m_rowv = 1'b1;
            if (wr) ref_mem[addr[AW-1:2]] = data;
            else    e.rdata = ref_mem[addr[AW-1:2]];
        end
        e.row = m_row; e.rowv = m_rowv;
        e.when = cyc + 1 + lat;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R1", "ready after accept", cmd_ready, 0);
        check("R9", "stall in flight", core_stall,
              blocking_mode ? (NC'(1) << core) : NC'(0));
    endtask

    // Monitor: compare each completion with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && done_valid) begin
            if (sb.size() == 0) begin
                check("R5", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, "done cycle", cyc, e.when);
                check("R5", "done tag", done_tag, e.tag);
                check("R5", "done data", done_rdata, e.rdata);
                check(e.req, "done error", done_error, e.err);
                check("R8", "open row", open_row, e.row);
                check("R8", "open row valid", open_row_valid, e.rowv);
                check("R1", "ready at done", cmd_ready, 1);
                check("R9", "stall at done", core_stall, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10", "done in reset", done_valid, 0);
        check("R10", "ready in reset", cmd_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "stall after reset", core_stall, 0);
        check("R8", "row valid after reset", open_row_valid, 0);

        // Blocking mode, core 0.
        issue(1, 2'd0, 10'h000, 32'hA5A5_0001, 4'd1, "R3");  // empty buffer
        issue(0, 2'd0, 10'h000, '0,           4'd2, "R2");  // hit
        issue(1, 2'd0, 10'h004, 32'h0000_BEEF, 4'd3, "R2");  // hit, write
        issue(1, 2'd0, 10'h040, 32'h1234_5678, 4'd4, "R4");  // miss
        issue(0, 2'd0, 10'h000, '0,           4'd5, "R4");  // miss back
        issue(0, 2'd0, 10'h002, '0,           4'd6, "R6");  // misaligned
        issue(1, 2'd1, 10'h000, 32'hDEAD_DEAD, 4'd7, "R7");  // foreign write
        issue(0, 2'd0, 10'h000, '0,           4'd8, "R7");  // unchanged, hit
        issue(0, 2'd0, 10'h040, '0,           4'd9, "R4");
        // Non-blocking mode, other cores.
        blocking_mode = 1'b0;
        issue(1, 2'd2, 10'h204, 32'hCAFE_0002, 4'd10, "R4");
        issue(0, 2'd2, 10'h204, '0,            4'd11, "R2");
        issue(1, 2'd3, 10'h3FC, 32'h0F0F_0F0F, 4'd12, "R4");
        issue(0, 2'd3, 10'h3FD, '0,            4'd13, "R6");
        issue(0, 2'd3, 10'h3FC, '0,            4'd14, "R2");
        issue(0, 2'd2, 10'h304, '0,            4'd15, "R7");
        issue(0, 2'd0, 10'h004, '0,            4'd0,  "R4");

        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule